// File: doc/BRIEF.md
# Cascaded Programmable Duty-Cycle Clock Divider

This block is one channel of a clock distribution tree. Two divider stages sit in series. Each stage makes a square wave whose high time and low time are set separately, so both the ratio and the duty cycle can be programmed. The first stage's waveform is the input clock of the second stage, and either stage can be taken out of the path. A chip-wide synchronization pulse restarts both stages together. Each stage can hold a programmed level for a programmed number of its own input cycles before it starts. Several channels can therefore be lined up with fixed phase relations.

Settings arrive through a small word-wide write port and are first written to pending registers. They are copied into the active (shadow) registers only when a synchronization pulse is obeyed, so a running waveform never changes in the middle of a period. A control word holds two bits that act at once. The ignore-sync bit makes the channel disregard synchronization pulses, and the force bit then sets the static level of the output.

Each stage is a state machine with four states:
- `S_IDLE` is the level after reset, and also the state of a bypassed stage.
- `S_OFFSET` holds the start level during the phase offset.
- `S_HIGH` and `S_LOW` are the two halves of a period.

The transitions are:
- *sync-load*: from any state to `S_OFFSET`, `S_HIGH`, `S_LOW` or `S_IDLE`, taken on an obeyed sync pulse.
- *offset-done*: from `S_OFFSET` to the start phase.
- *high-done*: from `S_HIGH` to `S_LOW`.
- *low-done*: from `S_LOW` to `S_HIGH`.

The last three are taken on an input tick of the stage while its counter is zero. A tick is one cycle of `clk_i` for stage 1. For stage 2 it is one rising edge of stage 1's waveform.

Top module: `cdiv_chan`

## Requirements
- R1: After reset, and until the first obeyed sync pulse, `clk_o` is low.
- R2: A stage with high field H and low field L alternates between H+1 input cycles high and L+1 input cycles low. A field value of 0 gives a phase one cycle long.
- R3: A sync pulse is obeyed when `sync_i` is high at a rising edge of `clk_i` while the ignore-sync bit is clear. The new waveform starts in the cycle right after that edge. Each stage then holds its start level (bit 12: 1 = high, 0 = low) for P input cycles, where P is its offset field. It then runs a full start-level phase, followed by the opposite phase.
- R4: With no stage bypassed, stage 2 counts rising edges of stage 1's waveform, and `clk_o` is stage 2's waveform.
- R5: A bypassed stage (bit 13 = 1) passes its input through unchanged. With only stage 1 bypassed, stage 2 counts `clk_i` cycles. With only stage 2 bypassed, `clk_o` is stage 1's waveform.
- R6: With both stages bypassed, `clk_o` follows `clk_i`.
- R7: The stage words are written at address 0 (stage 1) and address 1 (stage 2). Their fields are: high count in bits 3:0, low count in bits 7:4, offset in bits 11:8, start level in bit 12 and bypass in bit 13. A write changes nothing on `clk_o` until the next obeyed sync pulse loads it.
- R8: Address 2 bit 0 is the ignore-sync bit, and it takes effect in the cycle after the write. While it is set, sync pulses neither restart the stages nor load pending settings. After it is cleared, `clk_o` continues the waveform that was already running, in the same phase.
- R9: While the ignore-sync bit is set, `clk_o` is held at address 2 bit 1 (1 = high, 0 = low), starting in the cycle after the write. With the bit clear, bit 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Chip-level synchronization pulse, sampled on `clk_i` |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word address |
| cfg_wdata_i | input | 14 | Configuration write data |
| clk_o | output | 1 | Divided (or forced, or passed-through) clock |

## Verification
The divider runs with the following settings:
- Unequal high and low counts: a wrong half-period length shows up.
- Zero counts, giving divide-by-two: tells an N+1 count apart from an N count.
- A non-zero offset with start level low: separates the offset hold from the start-level phase.
- A cascade of both stages: shows whether stage 2 counts stage 1 edges rather than input cycles.
- Each bypass combination.

A mid-period write followed by a late sync pulse tells shadowed settings apart from immediate ones. While the force mode is active, a sync pulse is issued with new settings pending. Once the mode is cleared, the phase that resumes shows whether that pulse was truly ignored.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    // Width of every per-stage count field.
    localparam int CNT_W = 4;
    // Stage word: {bypass, start, offset, low, high}; the packed order is the write layout.
    localparam int CFG_W = 3 * CNT_W + 2;

    typedef struct packed {
        logic             byp;
        logic             start;
        logic [CNT_W-1:0] off;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
    } stage_cfg_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_OFFSET,
        S_HIGH,
        S_LOW
    } stage_st_t;
endpackage

// File: rtl/cdiv_cfg.sv
module cdiv_cfg
    import cdiv_pkg::*;
#(
    parameter int NUM_STAGES = 2,
    parameter int ADDR_W     = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       sync_i,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [CFG_W-1:0]           wdata_i,
    output stage_cfg_t [NUM_STAGES-1:0] pend_o,
    output stage_cfg_t [NUM_STAGES-1:0] active_o,
    output logic                       nosync_o,
    output logic                       force_o,
    output logic                       sync_ok_o
);
    stage_cfg_t [NUM_STAGES-1:0] pend_q;
    stage_cfg_t [NUM_STAGES-1:0] active_q;
    logic                        nosync_q;
    logic                        force_q;

    assign sync_ok_o = sync_i & ~nosync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q   <= '0;
            active_q <= '0;
            nosync_q <= 1'b0;
            force_q  <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_STAGES; i++) begin
                if (we_i && addr_i == ADDR_W'(i)) begin
                    pend_q[i] <= stage_cfg_t'(wdata_i);
                end
            end
            if (we_i && addr_i == ADDR_W'(NUM_STAGES)) begin
                nosync_q <= wdata_i[0];
                force_q  <= wdata_i[1];
            end
            if (sync_ok_o) begin
                active_q <= pend_q;
            end
        end
    end

    assign pend_o   = pend_q;
    assign active_o = active_q;
    assign nosync_o = nosync_q;
    assign force_o  = force_q;

    // R7: active settings move only on an obeyed sync pulse
    a_r7_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_ok_o |=> $stable(active_q));
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage
    import cdiv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sync_i,
    input  logic       adv_i,
    input  stage_cfg_t cfg_i,
    input  stage_cfg_t cfg_new_i,
    output logic       lvl_o,
    output logic       rise_o
);
    stage_st_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lvl_d;

    function automatic logic level_of(stage_st_t s, logic start);
        unique case (s)
            S_IDLE:   return 1'b0;
            S_OFFSET: return start;
            S_HIGH:   return 1'b1;
            S_LOW:    return 1'b0;
        endcase
    endfunction

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (sync_i) begin
            if (cfg_new_i.byp) begin
                st_d  = S_IDLE;
                cnt_d = '0;
            end else if (cfg_new_i.off != '0) begin
                st_d  = S_OFFSET;
                cnt_d = cfg_new_i.off - 1'b1;
            end else if (cfg_new_i.start) begin
                st_d  = S_HIGH;
                cnt_d = cfg_new_i.hi;
            end else begin
                st_d  = S_LOW;
                cnt_d = cfg_new_i.lo;
            end
        end else if (adv_i && !cfg_i.byp) begin
            unique case (st_q)
                S_IDLE: begin
                    st_d = S_IDLE;
                end
                S_OFFSET: begin
                    if (cnt_q == '0) begin
                        st_d  = cfg_i.start ? S_HIGH : S_LOW;
                        cnt_d = cfg_i.start ? cfg_i.hi : cfg_i.lo;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                S_HIGH: begin
                    if (cnt_q == '0) begin
                        st_d  = S_LOW;
                        cnt_d = cfg_i.lo;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                S_LOW: begin
                    if (cnt_q == '0) begin
                        st_d  = S_HIGH;
                        cnt_d = cfg_i.hi;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        lvl_o  = level_of(st_q, cfg_i.start);
        lvl_d  = level_of(st_d, cfg_i.start);
        rise_o = adv_i & ~sync_i & lvl_d & ~lvl_o;
    end

    // R3: first cycle after an obeyed sync shows the new start level
    a_r3_sync_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && !cfg_new_i.byp) |=> (lvl_o == $past(cfg_new_i.start)));

    // R2: level only moves when a phase counter expires on a tick
    a_r2_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sync_i && !(adv_i && cnt_q == '0)) |=> $stable(lvl_o));
endmodule

// File: rtl/cdiv_chan.sv
module cdiv_chan
    import cdiv_pkg::*;
#(
    parameter int NUM_STAGES = 2,
    localparam int ADDR_W    = $clog2(NUM_STAGES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sync_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic              clk_o
);
    stage_cfg_t [NUM_STAGES-1:0] pend, active;
    logic                        nosync, force_lvl, sync_ok;
    logic [NUM_STAGES-1:0]       adv, lvl, rise;
    logic [NUM_STAGES:0]         lvl_chain, clk_path;
    logic                        sel_clk, out_lvl;

    cdiv_cfg #(
        .NUM_STAGES(NUM_STAGES),
        .ADDR_W    (ADDR_W)
    ) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sync_i   (sync_i),
        .we_i     (cfg_we_i),
        .addr_i   (cfg_addr_i),
        .wdata_i  (cfg_wdata_i),
        .pend_o   (pend),
        .active_o (active),
        .nosync_o (nosync),
        .force_o  (force_lvl),
        .sync_ok_o(sync_ok)
    );

    assign adv[0]       = 1'b1;
    assign lvl_chain[0] = 1'b0;
    assign clk_path[0]  = 1'b1;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        cdiv_stage u_stage (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sync_i   (sync_ok),
            .adv_i    (adv[i]),
            .cfg_i    (active[i]),
            .cfg_new_i(pend[i]),
            .lvl_o    (lvl[i]),
            .rise_o   (rise[i])
        );
        assign lvl_chain[i+1] = active[i].byp ? lvl_chain[i] : lvl[i];
        assign clk_path[i+1]  = active[i].byp & clk_path[i];
        if (i + 1 < NUM_STAGES) begin : g_tick
            assign adv[i+1] = active[i].byp ? adv[i] : rise[i];
        end
    end

    assign sel_clk = ~nosync & clk_path[NUM_STAGES];
    assign out_lvl = nosync ? force_lvl : lvl_chain[NUM_STAGES];
    // Gated-logic clock select between pass-through and divided level.
    assign clk_o   = (sel_clk & clk_i) | (~sel_clk & out_lvl);

    // R9: a forced output stays put while the force value is unchanged
    a_r9_force_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nosync && $past(nosync) && $stable(force_lvl)) |-> $stable(clk_o));
endmodule

// File: tb/tb_cdiv_chan.sv
`timescale 1ns/1ps
module tb_cdiv_chan;
    import cdiv_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync = 1'b0;
    logic              we = 1'b0;
    logic [1:0]        addr = '0;
    logic [CFG_W-1:0]  wdata = '0;
    logic              clk_out;

    cdiv_chan dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sync_i     (sync),
        .cfg_we_i   (we),
        .cfg_addr_i (addr),
        .cfg_wdata_i(wdata),
        .clk_o      (clk_out)
    );

    always #2.5 clk = ~clk;

    int         n_tests = 0;
    int         n_fail  = 0;
    int         cyc     = 0;
    int         sync_cyc = 0;
    bit         done    = 1'b0;
    logic       exp_q[$];
    string      tag_q[$];
    stage_cfg_t m_pend[2];
    stage_cfg_t m_act[2];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: clk_o=%b expected %b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, clk_out, e);
        end
    end

    function automatic stage_cfg_t mk(bit b, bit s, int o, int l, int h);
        stage_cfg_t c;
        c.byp = b; c.start = s;
        c.off = CNT_W'(o); c.lo = CNT_W'(l); c.hi = CNT_W'(h);
        return c;
    endfunction

    // Level of one stage after m input ticks since sync
    function automatic logic stage_lvl(int m, stage_cfg_t c);
        int a, b, u;
        if (m < int'(c.off)) return c.start;
        u = m - int'(c.off);
        a = c.start ? int'(c.hi) + 1 : int'(c.lo) + 1;
        b = c.start ? int'(c.lo) + 1 : int'(c.hi) + 1;
        return ((u % (a + b)) < a) ? c.start : ~c.start;
    endfunction

    // Channel output at cycle t after sync, sampled while clk is low
    function automatic logic chan_lvl(int t);
        int m2 = 0;
        if (m_act[0].byp && m_act[1].byp) return 1'b0;
        if (m_act[1].byp) return stage_lvl(t, m_act[0]);
        if (m_act[0].byp) return stage_lvl(t, m_act[1]);
        for (int k = 1; k <= t; k++) begin
            if (stage_lvl(k, m_act[0]) && !stage_lvl(k - 1, m_act[0])) m2++;
        end
        return stage_lvl(m2, m_act[1]);
    endfunction

    task automatic wr(logic [1:0] a, logic [CFG_W-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        if (a < 2) m_pend[a] = stage_cfg_t'(d);
    endtask

    task automatic wr_stage(int idx, stage_cfg_t c);
        wr(2'(idx), CFG_W'(c));
    endtask

    task automatic do_sync();
        @(negedge clk);
        sync = 1'b1;
        @(posedge clk);
        #1;
        sync = 1'b0;
        sync_cyc = cyc;
        m_act[0] = m_pend[0];
        m_act[1] = m_pend[1];
    endtask

    task automatic push_run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(chan_lvl(cyc - sync_cyc + i));
            tag_q.push_back(tag);
        end
    endtask

    task automatic push_const(int n, logic v, string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        m_pend[0] = '0; m_pend[1] = '0;
        m_act[0]  = '0; m_act[1]  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: low after reset, no sync yet
        @(posedge clk); #1;
        push_const(8, 1'b0, "R1");
        drain();

        // R2: unequal high/low, stage 2 bypassed
        wr_stage(0, mk(0, 1, 0, 4, 2));
        wr_stage(1, mk(1, 0, 0, 0, 0));
        do_sync();
        push_run(40, "R2");
        drain();

        // R2: zero fields give a divide by two
        wr_stage(0, mk(0, 1, 0, 0, 0));
        do_sync();
        push_run(16, "R2");
        drain();

        // R3: offset hold, start low
        wr_stage(0, mk(0, 0, 5, 2, 1));
        do_sync();
        push_run(40, "R3");
        drain();

        // R4: both stages active in cascade
        wr_stage(0, mk(0, 1, 0, 0, 0));
        wr_stage(1, mk(0, 1, 1, 2, 1));
        do_sync();
        push_run(80, "R4");
        drain();

        // R5: stage 1 bypassed, stage 2 counts input cycles
        wr_stage(0, mk(1, 0, 0, 0, 0));
        wr_stage(1, mk(0, 0, 2, 1, 3));
        do_sync();
        push_run(40, "R5");
        drain();

        // R6: both bypassed, output follows input clock
        wr_stage(1, mk(1, 0, 0, 0, 0));
        do_sync();
        push_run(10, "R6");
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            check("R6", clk_out, 1'b1);
        end
        drain();

        // R7: mid-run write has no effect until the next sync
        wr_stage(0, mk(0, 1, 0, 2, 2));
        wr_stage(1, mk(1, 0, 0, 0, 0));
        do_sync();
        push_run(60, "R7");
        repeat (15) @(negedge clk);
        wr_stage(0, mk(0, 0, 0, 0, 0));
        drain();
        do_sync();
        push_run(20, "R7");
        drain();

        // R8/R9: ignore-sync with forced level
        wr_stage(0, mk(0, 1, 0, 3, 1));
        do_sync();
        push_run(20, "R8");
        drain();
        wr(2'd2, CFG_W'(3));
        @(posedge clk); #1;
        push_const(20, 1'b1, "R9");
        wr_stage(0, mk(0, 0, 3, 0, 0));
        @(negedge clk);
        sync = 1'b1;
        @(posedge clk); #1;
        sync = 1'b0;
        drain();
        wr(2'd2, CFG_W'(1));
        @(posedge clk); #1;
        push_const(6, 1'b0, "R9");
        drain();
        wr(2'd2, CFG_W'(0));
        @(posedge clk); #1;
        push_run(30, "R8");
        drain();

        // R9: force bit alone has no effect with ignore-sync clear
        wr(2'd2, CFG_W'(2));
        @(posedge clk); #1;
        push_run(20, "R9");
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule